// File: doc/BRIEF.md
# Timer Tick Source Selector

This block decides when an 8-bit timer advances. It produces a strobe, `tick_o`, that is high for exactly one system clock each time the timer should count. The counter downstream uses the strobe as a clock enable and stays in the system clock domain. A 3-bit select field picks the source of the strobe: no source at all, the raw system clock, one of four taps of a free-running 10-bit divider, or an event pin.

The event pin passes through a two-stage synchronizer and an edge detector. The selected polarity, falling or rising, produces one strobe per edge. The divider runs whatever source is selected, so switching between divided taps keeps a single global phase. A synchronous clear input puts the divider back to zero, and software or a neighbouring timer can use it to align the first divided tick.

Top module: `tmr_clk_select`

## Requirements
- R1: While `rst` is high, and in the cycle after reset is sampled, `tick_o` is 0 and the divider is zero.
- R2: With select code 0 (off), `tick_o` stays 0 whatever the event pin and clear input do.
- R3: With select code 1, `tick_o` is 1 in every cycle, one cycle after the code is applied.
- R4: Select codes 2, 3, 4 and 5 give divide ratios N of 8, 64, 256 and 1024. When the divider clear is sampled at edge 0, `tick_o` is high after edge j exactly when j is a positive multiple of N.
- R5: While the divider clear input is held high, a divided select (codes 2 to 5) produces no tick. After the clear is released, the first tick comes N cycles after the last clear edge.
- R6: Select code 6 produces one tick for each falling edge of the event pin. If the pin is sampled low at edge k after being sampled high at edge k-1, the tick is high after edge k+2.
- R7: Select code 7 does the same for rising edges: pin sampled high at edge k after low at edge k-1 gives a tick after edge k+2.
- R8: In event mode, edges of the opposite polarity and a steady pin produce no tick.
- R9: The divider counts in every select mode, so a divided tap selected later ticks on the phase set by the last clear, not on the moment of selection.
- R10: In divided and event modes, `tick_o` is never high in two consecutive cycles while the select code is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_sel_i | input | 3 | Tick source select code |
| ext_evt_i | input | 1 | Asynchronous event pin |
| psc_clr_i | input | 1 | Synchronous divider clear |
| tick_o | output | 1 | One-cycle count-enable strobe |

## Verification
Each divided tap is swept over more than two full periods after a clear, with an expected value for every cycle. This separates a wrong tap width, an off-by-one phase and a missing wrap. The event modes are driven with three pin patterns: a toggle every cycle, a pseudo-random sequence and runs of growing length. A cycle-accurate model of the synchronizer delay predicts each tick, so an extra stage, swapped polarity or a double count on one edge all show up. Selecting a tap partway through a divider period, and holding the clear, separate a free-running divider from one that restarts when the select code changes.

// File: rtl/tmr_clk_pkg.sv
`timescale 1ns/1ps
package tmr_clk_pkg;

  typedef enum logic [2:0] {
    CS_OFF      = 3'd0,
    CS_DIV1     = 3'd1,
    CS_DIV8     = 3'd2,
    CS_DIV64    = 3'd3,
    CS_DIV256   = 3'd4,
    CS_DIV1024  = 3'd5,
    CS_EXT_FALL = 3'd6,
    CS_EXT_RISE = 3'd7
  } clk_sel_e;

  localparam int NUM_TAPS = 4;

  // log2 of the divide ratio for tap index 0..NUM_TAPS-1
  function automatic int tap_shift(input int idx);
    case (idx)
      0:       return 3;
      1:       return 6;
      2:       return 8;
      default: return 10;
    endcase
  endfunction

endpackage

// File: rtl/tmr_prescaler.sv
`timescale 1ns/1ps
module tmr_prescaler
  import tmr_clk_pkg::*;
#(
  parameter int PSC_W = 10
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                clr_i,
  output logic [NUM_TAPS-1:0] tap_o
);

  logic [PSC_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr_i) cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end

  // a tap fires on the last count of its period
  for (genvar gi = 0; gi < NUM_TAPS; gi++) begin : g_tap
    localparam int SH = tap_shift(gi);
    if (SH <= PSC_W) begin : g_ok
      assign tap_o[gi] = &cnt_q[SH-1:0];
    end else begin : g_none
      assign tap_o[gi] = 1'b0;
    end
  end

endmodule

// File: rtl/tmr_ext_edge.sv
`timescale 1ns/1ps
module tmr_ext_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   hist_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      hist_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
      hist_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign rise_o =  sync_q[SYNC_STAGES-1] & ~hist_q;
  assign fall_o = ~sync_q[SYNC_STAGES-1] &  hist_q;

endmodule

// File: rtl/tmr_tick_mux.sv
`timescale 1ns/1ps
module tmr_tick_mux
  import tmr_clk_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic [2:0]          sel_i,
  input  logic [NUM_TAPS-1:0] tap_i,
  input  logic                rise_i,
  input  logic                fall_i,
  output logic                tick_o
);

  clk_sel_e sel;
  logic     tick_d;
  logic [1:0] tap_idx;

  assign sel     = clk_sel_e'(sel_i);
  assign tap_idx = 2'(sel_i - 3'd2);

  always_comb begin
    case (sel)
      CS_OFF:      tick_d = 1'b0;
      CS_DIV1:     tick_d = 1'b1;
      CS_EXT_FALL: tick_d = fall_i;
      CS_EXT_RISE: tick_d = rise_i;
      default:     tick_d = tap_i[tap_idx];
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) tick_o <= 1'b0;
    else     tick_o <= tick_d;
  end

endmodule

// File: rtl/tmr_clk_select.sv
`timescale 1ns/1ps
module tmr_clk_select
  import tmr_clk_pkg::*;
#(
  parameter int PSC_W       = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] clk_sel_i,
  input  logic       ext_evt_i,
  input  logic       psc_clr_i,
  output logic       tick_o
);

  logic [NUM_TAPS-1:0] taps;
  logic                ev_rise;
  logic                ev_fall;

  tmr_prescaler #(.PSC_W(PSC_W)) u_psc (
    .clk   (clk),
    .rst   (rst),
    .clr_i (psc_clr_i),
    .tap_o (taps)
  );

  tmr_ext_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk    (clk),
    .rst    (rst),
    .pin_i  (ext_evt_i),
    .rise_o (ev_rise),
    .fall_o (ev_fall)
  );

  tmr_tick_mux u_mux (
    .clk    (clk),
    .rst    (rst),
    .sel_i  (clk_sel_i),
    .tap_i  (taps),
    .rise_i (ev_rise),
    .fall_i (ev_fall),
    .tick_o (tick_o)
  );

endmodule

// File: rtl/tmr_clk_select_chk.sv
`timescale 1ns/1ps
module tmr_clk_select_chk (
  input logic       clk,
  input logic       rst,
  input logic [2:0] clk_sel_i,
  input logic       psc_clr_i,
  input logic       tick_o
);

  logic seen_rst = 1'b0;
  always_ff @(posedge clk) if (rst) seen_rst <= 1'b1;

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> !tick_o);

  // R2
  off_quiet_chk: assert property (@(posedge clk) disable iff (rst || !seen_rst)
    (!$past(rst) && $past(clk_sel_i) == 3'd0) |-> !tick_o);

  // R3
  div1_every_chk: assert property (@(posedge clk) disable iff (rst || !seen_rst)
    (!$past(rst) && $past(clk_sel_i) == 3'd1) |-> tick_o);

  // R5
  clr_restart_chk: assert property (@(posedge clk) disable iff (rst || !seen_rst)
    ($past(psc_clr_i) && clk_sel_i >= 3'd2 && clk_sel_i <= 3'd5) |=> !tick_o);

  // R10
  single_pulse_chk: assert property (@(posedge clk) disable iff (rst || !seen_rst)
    (tick_o && clk_sel_i >= 3'd2 && clk_sel_i == $past(clk_sel_i)) |=> !tick_o);

endmodule

bind tmr_clk_select tmr_clk_select_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .clk_sel_i (clk_sel_i),
  .psc_clr_i (psc_clr_i),
  .tick_o    (tick_o)
);

// File: tb/sim_tmr_clk_select.sv
`timescale 1ns/1ps
module sim_tmr_clk_select;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] clk_sel_i = 3'd0;
  logic       ext_evt_i = 1'b0;
  logic       psc_clr_i = 1'b0;
  logic       tick_o;

  int n_chk  = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  tmr_clk_select u0 (
    .clk       (clk),
    .rst       (rst),
    .clk_sel_i (clk_sel_i),
    .ext_evt_i (ext_evt_i),
    .psc_clr_i (psc_clr_i),
    .tick_o    (tick_o)
  );

  task automatic check(input logic got, input logic exp, input string req);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: tick_o=%0b expected %0b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // clear divider at edge 0, then compare every cycle against j % N
  task automatic run_div(input logic [2:0] s, input int n);
    clk_sel_i = s;
    psc_clr_i = 1'b1;
    step(1);
    psc_clr_i = 1'b0;
    for (int j = 1; j <= 2 * n + 3; j++) begin
      step(1);
      check(tick_o, (j % n) == 0, "R4");
    end
  endtask

  // event mode with a per-cycle model of sync delay
  task automatic run_ext(input logic [2:0] s, input int mode, input int cycles);
    logic h0, h1, h2, h3, exp_t;
    logic [7:0] lfsr;
    int run_len, run_cnt;
    lfsr = 8'hA5; run_len = 1; run_cnt = 0;
    clk_sel_i = s;
    ext_evt_i = 1'b0;
    step(5);
    h0 = 1'b0; h1 = 1'b0; h2 = 1'b0; h3 = 1'b0;
    for (int c = 0; c < cycles; c++) begin
      step(1);
      h3 = h2; h2 = h1; h1 = h0; h0 = ext_evt_i;
      exp_t = (s == 3'd6) ? (~h2 & h3) : (h2 & ~h3);
      if (s == 3'd6) check(tick_o, exp_t, exp_t ? "R6" : "R8");
      else           check(tick_o, exp_t, exp_t ? "R7" : "R8");
      case (mode)
        0: ext_evt_i = ~ext_evt_i;
        1: begin
          lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
          ext_evt_i = lfsr[0];
        end
        default: begin
          run_cnt++;
          if (run_cnt >= run_len) begin
            run_cnt = 0;
            run_len = (run_len % 5) + 1;
            ext_evt_i = ~ext_evt_i;
          end
        end
      endcase
    end
    ext_evt_i = 1'b0;
    step(5);
  endtask

  initial begin
    step(3);
    check(tick_o, 1'b0, "R1");
    rst = 1'b0;
    step(1);
    check(tick_o, 1'b0, "R1");

    // R3: every cycle
    clk_sel_i = 3'd1;
    step(1);
    for (int j = 0; j < 20; j++) begin
      step(1);
      check(tick_o, 1'b1, "R3");
    end

    // R2: off, with pin and clear activity
    clk_sel_i = 3'd0;
    step(1);
    for (int j = 0; j < 40; j++) begin
      ext_evt_i = j[1];
      psc_clr_i = (j % 7) == 0;
      step(1);
      check(tick_o, 1'b0, "R2");
    end
    ext_evt_i = 1'b0;
    psc_clr_i = 1'b0;

    // R4: each divided tap
    run_div(3'd2, 8);
    run_div(3'd3, 64);
    run_div(3'd4, 256);
    run_div(3'd5, 1024);

    // R9: select a tap mid-period; phase follows the clear
    clk_sel_i = 3'd0;
    psc_clr_i = 1'b1;
    step(1);
    psc_clr_i = 1'b0;
    for (int j = 1; j <= 40; j++) begin
      step(1);
      if (j >= 6) check(tick_o, (j % 8) == 0, "R9");
      if (j == 5) clk_sel_i = 3'd2;
    end

    // R5: clear held blocks ticks, then restarts phase
    clk_sel_i = 3'd2;
    psc_clr_i = 1'b1;
    step(2);
    for (int j = 0; j < 30; j++) begin
      step(1);
      check(tick_o, 1'b0, "R5");
    end
    psc_clr_i = 1'b0;
    for (int j = 1; j <= 17; j++) begin
      step(1);
      check(tick_o, (j % 8) == 0, "R5");
    end

    // R6 R7 R8: event modes, three pin patterns each
    for (int m = 0; m < 3; m++) begin
      run_ext(3'd6, m, 120);
      run_ext(3'd7, m, 120);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not complete");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule